// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multicycle processor, built as a microprogram. A microprogram counter selects one word of a ten-entry microcode store. Each word carries the datapath control fields and a two-bit sequencing field. The sequencing field decides where the counter goes next. It can return to the fetch word, step to the next word, or jump through one of two dispatch tables. Both tables are indexed by the opcode of the current instruction.

The datapath is outside this block. The surrounding design holds the instruction register and presents its opcode bits on `opcode`. It then applies the control fields on `ctrl_word`. The current micro-address is also brought out on `uaddr`.

The micro-addresses and their names are:

| Address | Name | Role |
|---|---|---|
| 0 | FETCH | fetch the instruction |
| 1 | DECODE | decode the instruction |
| 2 | ADDR | compute the memory address |
| 3 | LOAD | read memory |
| 4 | LOAD_WB | write back loaded data |
| 5 | STORE | write memory |
| 6 | EXEC | ALU operation on registers |
| 7 | REG_WB | write back ALU result |
| 8 | BRANCH | conditional branch |
| 9 | JUMP | unconditional jump |

The transitions are:

- FETCH to DECODE (step).
- DECODE to a state chosen by the first dispatch table.
- ADDR to a state chosen by the second dispatch table.
- LOAD to LOAD_WB and EXEC to REG_WB (step).
- LOAD_WB, STORE, REG_WB, BRANCH and JUMP back to FETCH.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `uaddr` is 0 (FETCH). Reset takes effect without waiting for a clock edge, also in the middle of an instruction.
- R2: The sequencing field is `ctrl_word[17:16]`. Its values are:
  - 00: return to address 0.
  - 01: use the first dispatch table.
  - 10: use the second dispatch table.
  - 11: use the current address plus one.

  The field's value at each address is:
  - 11 at addresses 0, 3 and 6.
  - 01 at address 1.
  - 10 at address 2.
  - 00 at addresses 4, 5, 7, 8 and 9.
- R3: Address 0 is always followed by address 1.
- R4: At address 1 the next address comes from the first dispatch table:
  - opcode 000000 goes to 6.
  - opcode 000010 goes to 9.
  - opcode 000100 goes to 8.
  - opcodes 100011 and 101011 go to 2.
  - any other opcode goes to 0.
- R5: At address 2 the next address comes from the second dispatch table:
  - opcode 100011 goes to 3.
  - opcode 101011 goes to 5.
  - any other opcode goes to 0.
- R6: Address 3 is followed by 4, and address 6 is followed by 7.
- R7: Addresses 4, 5, 7, 8 and 9 are followed by address 0.
- R8: The control word has this field layout:
  - [15:14] alu_op.
  - [13] src_a.
  - [12:11] src_b.
  - [10:9] pc_src.
  - [8] pc_wr.
  - [7] pc_wr_cond.
  - [6] mem_rd.
  - [5] mem_wr.
  - [4] addr_sel.
  - [3] ir_wr.
  - [2] reg_wr.
  - [1] dst_sel.
  - [0] wb_sel.

  At address 0 the word sets mem_rd, ir_wr and pc_wr, with src_b=01, src_a=0, alu_op=00 and pc_src=00. All other fields are 0.
- R9: At address 1, src_a=0, src_b=11 and alu_op=00. No write or memory bit is set.
- R10: At address 2, src_a=1, src_b=10 and alu_op=00. At address 6, src_a=1, src_b=00 and alu_op=10. Neither address sets a write or memory bit.
- R11: At address 8, src_a=1, src_b=00, alu_op=01, pc_src=01 and pc_wr_cond=1. At address 9, pc_src=10 and pc_wr=1. All other fields at these two addresses are 0.
- R12: The memory and write-back addresses set only the following bits:
  - Address 3: mem_rd and addr_sel.
  - Address 5: mem_wr and addr_sel.
  - Address 4: reg_wr and wb_sel, with dst_sel=0.
  - Address 7: reg_wr and dst_sel, with wb_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge active |
| rst_n | input | 1 | asynchronous active-low reset |
| opcode | input | 6 | opcode bits of the held instruction |
| ctrl_word | output | 18 | microinstruction at the current address |
| uaddr | output | 4 | current micro-address |

## Verification
`uaddr` is registered, so the address chosen from the opcode and sequencing field appears one rising edge after the cycle in which they were presented. `ctrl_word` is a combinational function of `uaddr` and is valid in the same cycle. Reset drives `uaddr` to 0 at once, without an edge. The bench changes `opcode` and `rst_n` on falling edges. It compares `uaddr` and `ctrl_word` on the falling edge after each rising edge, and checks reset one time step after asserting it. Each instruction class, unlisted opcodes in both tables, and an opcode changed between dispatch steps are walked address by address.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int UA_W     = 4;
    localparam int OP_W     = 6;
    localparam int UA_DEPTH = 10;

    typedef enum logic [UA_W-1:0] {
        UA_FETCH   = 4'd0,
        UA_DECODE  = 4'd1,
        UA_ADDR    = 4'd2,
        UA_LOAD    = 4'd3,
        UA_LOAD_WB = 4'd4,
        UA_STORE   = 4'd5,
        UA_EXEC    = 4'd6,
        UA_REG_WB  = 4'd7,
        UA_BRANCH  = 4'd8,
        UA_JUMP    = 4'd9
    } ua_e;

    typedef enum logic [1:0] {
        SEQ_FETCH = 2'b00,
        SEQ_DISP1 = 2'b01,
        SEQ_DISP2 = 2'b10,
        SEQ_NEXT  = 2'b11
    } seq_e;

    localparam logic [OP_W-1:0] OP_ALU  = 6'b000000;
    localparam logic [OP_W-1:0] OP_JMP  = 6'b000010;
    localparam logic [OP_W-1:0] OP_BEQ  = 6'b000100;
    localparam logic [OP_W-1:0] OP_LOAD = 6'b100011;
    localparam logic [OP_W-1:0] OP_STOR = 6'b101011;

    typedef struct packed {
        seq_e       seq;
        logic [1:0] alu_op;
        logic       src_a;
        logic [1:0] src_b;
        logic [1:0] pc_src;
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_sel;
        logic       ir_wr;
        logic       reg_wr;
        logic       dst_sel;
        logic       wb_sel;
    } uinstr_t;

    localparam int CW_W = $bits(uinstr_t);
endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  ua_e     ua,
    output uinstr_t word
);
    always_comb begin
        word     = '0;
        word.seq = SEQ_FETCH;
        unique case (ua)
            UA_FETCH: begin
                word.seq    = SEQ_NEXT;
                word.mem_rd = 1'b1;
                word.ir_wr  = 1'b1;
                word.src_b  = 2'b01;
                word.pc_wr  = 1'b1;
            end
            UA_DECODE: begin
                word.seq   = SEQ_DISP1;
                word.src_b = 2'b11;
            end
            UA_ADDR: begin
                word.seq   = SEQ_DISP2;
                word.src_a = 1'b1;
                word.src_b = 2'b10;
            end
            UA_LOAD: begin
                word.seq      = SEQ_NEXT;
                word.mem_rd   = 1'b1;
                word.addr_sel = 1'b1;
            end
            UA_LOAD_WB: begin
                word.reg_wr = 1'b1;
                word.wb_sel = 1'b1;
            end
            UA_STORE: begin
                word.mem_wr   = 1'b1;
                word.addr_sel = 1'b1;
            end
            UA_EXEC: begin
                word.seq    = SEQ_NEXT;
                word.src_a  = 1'b1;
                word.alu_op = 2'b10;
            end
            UA_REG_WB: begin
                word.reg_wr  = 1'b1;
                word.dst_sel = 1'b1;
            end
            UA_BRANCH: begin
                word.src_a      = 1'b1;
                word.alu_op     = 2'b01;
                word.pc_src     = 2'b01;
                word.pc_wr_cond = 1'b1;
            end
            UA_JUMP: begin
                word.pc_src = 2'b10;
                word.pc_wr  = 1'b1;
            end
            default: begin
                word.seq = SEQ_FETCH;
            end
        endcase
    end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int TABLE = 1
) (
    input  logic [OP_W-1:0] op,
    output ua_e             target
);
    generate
        if (TABLE == 1) begin : g_first
            always_comb begin
                unique case (op)
                    OP_ALU:  target = UA_EXEC;
                    OP_JMP:  target = UA_JUMP;
                    OP_BEQ:  target = UA_BRANCH;
                    OP_LOAD: target = UA_ADDR;
                    OP_STOR: target = UA_ADDR;
                    default: target = UA_FETCH;
                endcase
            end
        end else begin : g_second
            always_comb begin
                unique case (op)
                    OP_LOAD: target = UA_LOAD;
                    OP_STOR: target = UA_STORE;
                    default: target = UA_FETCH;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  seq_e seq,
    input  ua_e  disp1,
    input  ua_e  disp2,
    output ua_e  ua
);
    ua_e             ua_nxt;
    logic [UA_W-1:0] ua_inc;

    assign ua_inc = ua + UA_W'(1);

    always_comb begin
        unique case (seq)
            SEQ_FETCH: ua_nxt = UA_FETCH;
            SEQ_DISP1: ua_nxt = disp1;
            SEQ_DISP2: ua_nxt = disp2;
            SEQ_NEXT:  ua_nxt = ua_e'(ua_inc);
            default:   ua_nxt = UA_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ua <= UA_FETCH;
        else        ua <= ua_nxt;
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [useq_pkg::OP_W-1:0]  opcode,
    output logic [useq_pkg::CW_W-1:0]  ctrl_word,
    output logic [useq_pkg::UA_W-1:0]  uaddr
);
    import useq_pkg::*;

    ua_e     ua;
    ua_e     disp1;
    ua_e     disp2;
    uinstr_t word;

    useq_rom u_rom (
        .ua   (ua),
        .word (word)
    );

    useq_dispatch #(.TABLE(1)) u_disp1 (
        .op     (opcode),
        .target (disp1)
    );

    useq_dispatch #(.TABLE(2)) u_disp2 (
        .op     (opcode),
        .target (disp2)
    );

    useq_next u_next (
        .clk   (clk),
        .rst_n (rst_n),
        .seq   (word.seq),
        .disp1 (disp1),
        .disp2 (disp2),
        .ua    (ua)
    );

    assign ctrl_word = word;
    assign uaddr     = ua;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  opcode,
    input logic [17:0] ctrl_word,
    input logic [3:0]  uaddr
);
    // R3
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == 4'd0 |=> uaddr == 4'd1);

    // R4
    decode_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == 4'd1 |=> (uaddr == 4'd0 || uaddr == 4'd2 || uaddr == 4'd6 ||
                           uaddr == 4'd8 || uaddr == 4'd9));

    // R5
    addr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == 4'd2 |=> (uaddr == 4'd0 || uaddr == 4'd3 || uaddr == 4'd5));

    // R6
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == 4'd3 || uaddr == 4'd6) |=> uaddr == $past(uaddr) + 4'd1);

    // R7
    return_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == 4'd4 || uaddr == 4'd5 || uaddr == 4'd7 ||
         uaddr == 4'd8 || uaddr == 4'd9) |=> uaddr == 4'd0);

    // R1
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr < 4'd10);

    // R8
    pc_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_word[8], ctrl_word[7], ctrl_word[5]}));

    // R5
    disp2_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == 4'd2 && opcode == 6'b100011) |=> uaddr == 4'd3);
endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .ctrl_word (ctrl_word),
    .uaddr     (uaddr)
);

// File: tb/useq_ctrl_bench.sv
module useq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = 6'd0;
    logic [17:0] ctrl_word;
    logic [3:0]  uaddr;
    int checks = 0;
    int errors = 0;

    useq_ctrl u_useq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (opcode),
        .ctrl_word (ctrl_word),
        .uaddr     (uaddr)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected word: {seq,alu_op,src_a,src_b,pc_src,pc_wr,pc_wr_cond,mem_rd,mem_wr,addr_sel,ir_wr,reg_wr,dst_sel,wb_sel}
    function automatic logic [17:0] exp_word(input logic [3:0] a);
        case (a)
            4'd0: return {2'b11, 2'b00, 1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
            4'd1: return {2'b01, 2'b00, 1'b0, 2'b11, 2'b00, 9'b0};
            4'd2: return {2'b10, 2'b00, 1'b1, 2'b10, 2'b00, 9'b0};
            4'd3: return {2'b11, 2'b00, 1'b0, 2'b00, 2'b00, 9'b001010000};
            4'd4: return {2'b00, 2'b00, 1'b0, 2'b00, 2'b00, 9'b000000101};
            4'd5: return {2'b00, 2'b00, 1'b0, 2'b00, 2'b00, 9'b000110000};
            4'd6: return {2'b11, 2'b10, 1'b1, 2'b00, 2'b00, 9'b0};
            4'd7: return {2'b00, 2'b00, 1'b0, 2'b00, 2'b00, 9'b000000110};
            4'd8: return {2'b00, 2'b01, 1'b1, 2'b00, 2'b01, 9'b010000000};
            4'd9: return {2'b00, 2'b00, 1'b0, 2'b00, 2'b10, 9'b100000000};
            default: return 18'h0;
        endcase
    endfunction

    function automatic string word_req(input logic [3:0] a);
        case (a)
            4'd0: return "R8";
            4'd1: return "R9";
            4'd2, 4'd6: return "R10";
            4'd8, 4'd9: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic string step_req(input logic [3:0] prev);
        case (prev)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3, 4'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic expect_at(input string req, input logic [3:0] a);
        check(req, "uaddr", 32'(uaddr), 32'(a));
        check(word_req(a), "ctrl_word", 32'(ctrl_word), 32'(exp_word(a)));
        check("R2", "seq field", 32'(ctrl_word[17:16]), 32'(exp_word(a) >> 16));
    endtask

    // walks one instruction from address 0; the last element is the return to 0
    task automatic run_seq(input string name, input logic [5:0] op, input int n,
                           input logic [3:0] e0, input logic [3:0] e1, input logic [3:0] e2,
                           input logic [3:0] e3, input logic [3:0] e4);
        logic [3:0] e [5];
        e = '{e0, e1, e2, e3, e4};
        opcode = op;
        for (int i = 0; i < n; i++) begin
            expect_at(i == 0 ? "R7" : step_req(e[i-1]), e[i]);
            @(negedge clk);
        end
        expect_at(step_req(e[n-1]), 4'd0);
        $display("scenario %s done", name);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "uaddr in reset", 32'(uaddr), 32'd0);
        check("R8", "word in reset", 32'(ctrl_word), 32'(exp_word(4'd0)));
        rst_n = 1'b1;
    endtask

    task automatic test_alu();    run_seq("alu",    6'b000000, 4, 0, 1, 6, 7, 0); endtask
    task automatic test_load();   run_seq("load",   6'b100011, 5, 0, 1, 2, 3, 4); endtask
    task automatic test_store();  run_seq("store",  6'b101011, 4, 0, 1, 2, 5, 0); endtask
    task automatic test_branch(); run_seq("branch", 6'b000100, 3, 0, 1, 8, 0, 0); endtask
    task automatic test_jump();   run_seq("jump",   6'b000010, 3, 0, 1, 9, 0, 0); endtask
    // R4: unlisted opcodes leave the first table at address 0
    task automatic test_unlisted1();
        run_seq("unlisted a", 6'b001000, 2, 0, 1, 0, 0, 0);
        run_seq("unlisted b", 6'b111111, 2, 0, 1, 0, 0, 0);
        run_seq("unlisted c", 6'b000011, 2, 0, 1, 0, 0, 0);
    endtask

    // R5: opcode swapped to one the second table lacks
    task automatic test_unlisted2();
        opcode = 6'b100011;
        expect_at("R7", 4'd0);
        @(negedge clk);
        expect_at("R3", 4'd1);
        @(negedge clk);
        expect_at("R4", 4'd2);
        opcode = 6'b000000;
        @(negedge clk);
        check("R5", "unlisted in table 2", 32'(uaddr), 32'd0);
    endtask

    // R1: reset in the middle of a load
    task automatic test_mid_reset();
        opcode = 6'b100011;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R6", "load reached", 32'(uaddr), 32'd3);
        rst_n = 1'b0;
        #1;
        check("R1", "async reset", 32'(uaddr), 32'd0);
        @(negedge clk);
        check("R1", "held in reset", 32'(uaddr), 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_alu();
        test_load();
        test_store();
        test_branch();
        test_jump();
        test_unlisted1();
        test_unlisted2();
        test_mid_reset();
        test_store();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule